// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a real address through a small set of programmable block windows. Each window is a pair of registers. The upper register holds a base page, a block-length code and two enable bits, one for each privilege state. The lower register holds a real base page and a two-bit protection code. A processor core would place one instance on the instruction side and one on the data side.

Translation is combinational from the address, access and state inputs. Register writes take effect on the clock edge. When relocation is enabled and no window covers the address, the block reports a miss, and a later segment and page stage can take over. When relocation is disabled, the address passes through unchanged.

Top module: `bat_xlate`

## Requirements
- R1: Reset, synchronous and active low, clears every register pair. After reset, every relocated access misses: hit=0, fault=0, ra=0.
- R2: When relocate_en=0, ra equals ea, and hit and fault are both 0, whatever the register contents and access type.
- R3: A pair takes part only if its enable bit for the current state is set. Upper bit 1 enables it in supervisor state (problem_state=0). Upper bit 0 enables it in problem state (problem_state=1).
- R4: Upper bits [12:2] form an 11-bit length code BL. The window mask is (BL<<17)|0x1FFFF. A pair matches when (ea & ~mask) equals upper & 0xFFFE0000.
- R5: On a permitted match, ra = (ea & mask) | (lower & 0xFFFE0000).
- R6: When several pairs match, the pair with the lowest index is used.
- R7: Lower bits [1:0] are the protection code. Code 00 denies every access. Codes 01 and 11 deny only stores. Code 10 allows everything. The access encoding is 00 load, 01 store and 10 fetch; code 11 is treated as a load.
- R8: On a denied match, hit=1, fault=1 and ra=0xFFFFFFFF.
- R9: When relocate_en=1 and no pair matches, hit=0, fault=0 and ra=0.
- R10: A write with wr_en=1 loads wr_data into the upper register (wr_lower=0) or the lower register (wr_lower=1) of pair wr_idx at the clock edge. The other register of that pair and all other pairs are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Pair selected for the write |
| wr_lower | input | 1 | 1 writes the lower register, 0 writes the upper |
| wr_data | input | 32 | Write data |
| relocate_en | input | 1 | Enables translation; 0 passes the address through |
| problem_state | input | 1 | 1 for the user state, 0 for the supervisor state |
| access | input | 2 | 00 load, 01 store, 10 fetch, 11 treated as load |
| ea | input | 32 | Effective address |
| hit | output | 1 | A window covers the address |
| fault | output | 1 | Protection violation on the matching window |
| ra | output | 32 | Real address |

## Verification
A vector table drives addresses just inside and just outside windows of the smallest, a middle and the largest length code. This separates a correct mask from one that is off by one bit. The same address is issued in both privilege states, and only the state-enable bits can tell those two cases apart. Each protection code is crossed with load, store, fetch and the spare code, which shows whether store-only denial differs from full denial. Two windows are then made to overlap: an address in both must resolve to the lower index, and an address in only the wider one must resolve to that window. Writing only one register of that pair confirms that its other register kept its value.

// File: rtl/bat_pkg.sv
// Shared definitions for the block address translation matcher.
// Assumes a two-bit access code that every instance decodes the same way.
package bat_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_SPARE = 2'b11
    } acc_e;

    localparam logic [1:0] PROT_NONE = 2'b00;
    localparam logic [1:0] PROT_RW   = 2'b10;
endpackage

// File: rtl/bat_pair_store.sv
// Register file that holds the upper and lower register of each window pair.
// Assumes one write per cycle. Reset is synchronous, active low, and clears every register.
module bat_pair_store #(
    parameter int NUM_PAIRS = 4,
    parameter int AW        = 32,
    localparam int IDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic                           wr_lower,
    input  logic [AW-1:0]                  wr_data,
    output logic [NUM_PAIRS-1:0][AW-1:0]   upper_q,
    output logic [NUM_PAIRS-1:0][AW-1:0]   lower_q
);
    // Clear on reset; otherwise load the addressed register on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_PAIRS; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    if (wr_lower) lower_q[i] <= wr_data;
                    else          upper_q[i] <= wr_data;
                end
            end
        end
    end

    // R10: without a write strobe, stored contents never move.
    a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(upper_q) && $stable(lower_q)));
endmodule

// File: rtl/bat_block_cmp.sv
// One window comparator. It builds the length mask from the length code,
// checks the state enable bit and the base page, and forms the translated address.
// Assumes BL_W + PAGE_SHIFT <= AW and that the length code starts at upper bit 2.
module bat_block_cmp #(
    parameter int AW         = 32,
    parameter int BL_W       = 11,
    parameter int PAGE_SHIFT = 17
) (
    input  logic [AW-1:0] upper,
    input  logic [AW-1:0] lower,
    input  logic [AW-1:0] ea,
    input  logic          problem,
    output logic          match,
    output logic [AW-1:0] ra_blk,
    output logic [1:0]    prot
);
    localparam int BASE_W = AW - PAGE_SHIFT;
    localparam logic [AW-1:0] LOW_ONES  = {{BASE_W{1'b0}}, {PAGE_SHIFT{1'b1}}};
    localparam logic [AW-1:0] BASE_MASK = {{BASE_W{1'b1}}, {PAGE_SHIFT{1'b0}}};

    logic [BL_W-1:0] len_code;
    logic [AW-1:0]   len_mask;
    logic            state_ok;
    wire             unused_bits = ^{upper[PAGE_SHIFT-1:BL_W+2], lower[PAGE_SHIFT-1:2]};

    // Decode the length mask and the state enable bit for this pair.
    always_comb begin
        len_code = upper[BL_W+1:2];
        len_mask = (AW'(len_code) << PAGE_SHIFT) | LOW_ONES;
        state_ok = problem ? upper[0] : upper[1];
    end

    // Compare the base page and build the translated address.
    always_comb begin
        match  = state_ok && ((ea & ~len_mask) == (upper & BASE_MASK));
        ra_blk = (ea & len_mask) | (lower & BASE_MASK);
        prot   = lower[1:0];
    end
endmodule

// File: rtl/bat_prot_chk.sv
// Protection decoder. It applies the fixed protection rules to the protection
// code of the selected window. Assumes the access encoding from bat_pkg.
module bat_prot_chk (
    input  logic [1:0] prot,
    input  logic [1:0] access,
    output logic       allow
);
    import bat_pkg::*;

    // Code 00 blocks all accesses, code 10 permits all, codes 01 and 11 block stores.
    always_comb begin
        if (prot == PROT_NONE)    allow = 1'b0;
        else if (prot == PROT_RW) allow = 1'b1;
        else                      allow = (acc_e'(access) != ACC_STORE);
    end
endmodule

// File: rtl/bat_xlate.sv
// Top-level matcher. It holds the window pairs, compares every pair in parallel,
// picks the lowest matching index, applies protection and drives hit, fault and ra.
// Assumes the register write port and the lookup share clk; the lookup path is combinational.
module bat_xlate #(
    parameter int NUM_PAIRS  = 4,
    parameter int AW         = 32,
    parameter int BL_W       = 11,
    parameter int PAGE_SHIFT = 17,
    localparam int IDX_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_lower,
    input  logic [AW-1:0]    wr_data,
    input  logic             relocate_en,
    input  logic             problem_state,
    input  logic [1:0]       access,
    input  logic [AW-1:0]    ea,
    output logic             hit,
    output logic             fault,
    output logic [AW-1:0]    ra
);
    import bat_pkg::*;

    logic [NUM_PAIRS-1:0][AW-1:0] upper_q, lower_q;
    logic [NUM_PAIRS-1:0][AW-1:0] ra_each;
    logic [NUM_PAIRS-1:0][1:0]    prot_each;
    logic [NUM_PAIRS-1:0]         match_each;
    logic [NUM_PAIRS-1:0]         winner;
    logic [AW-1:0]                win_ra;
    logic [1:0]                   win_prot;
    logic                         any_match;
    logic                         allow;

    bat_pair_store #(.NUM_PAIRS(NUM_PAIRS), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_lower(wr_lower), .wr_data(wr_data),
        .upper_q(upper_q), .lower_q(lower_q)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_cmp
        bat_block_cmp #(.AW(AW), .BL_W(BL_W), .PAGE_SHIFT(PAGE_SHIFT)) u_cmp (
            .upper(upper_q[g]), .lower(lower_q[g]), .ea(ea),
            .problem(problem_state), .match(match_each[g]),
            .ra_blk(ra_each[g]), .prot(prot_each[g])
        );
    end

    // Priority pick: the lowest matching index wins.
    always_comb begin
        winner    = '0;
        win_ra    = '0;
        win_prot  = '0;
        any_match = 1'b0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (match_each[i] && !any_match) begin
                any_match  = 1'b1;
                winner[i]  = 1'b1;
                win_ra     = ra_each[i];
                win_prot   = prot_each[i];
            end
        end
    end

    bat_prot_chk u_prot (.prot(win_prot), .access(access), .allow(allow));

    // Output select: pass-through, miss, protection fault or translated address.
    always_comb begin
        if (!relocate_en) begin
            hit = 1'b0; fault = 1'b0; ra = ea;
        end else if (!any_match) begin
            hit = 1'b0; fault = 1'b0; ra = '0;
        end else if (!allow) begin
            hit = 1'b1; fault = 1'b1; ra = '1;
        end else begin
            hit = 1'b1; fault = 1'b0; ra = win_ra;
        end
    end

    // R2: without relocation the address is passed through untouched.
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !relocate_en |-> (ra == ea && !hit && !fault));
    // R6: at most one window is selected.
    a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(winner));
    // R7: a fault needs a no-access code or a store.
    a_r7_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (win_prot == PROT_NONE || acc_e'(access) == ACC_STORE));
    // R8: a fault is always reported together with hit and an all-ones address.
    a_r8_fault_form: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (hit && ra == '1));
    // R9: a relocated miss drives a clean zero result.
    a_r9_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (relocate_en && !hit) |-> (ra == '0 && !fault));
endmodule

// File: tb/bat_xlate_bench.sv
module bat_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_lower, relocate_en, problem_state;
    logic [1:0]  wr_idx, access;
    logic [31:0] wr_data, ea, ra;
    logic        hit, fault;
    int          total = 0, bad = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    bat_xlate u_bat_xlate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_lower(wr_lower), .wr_data(wr_data), .relocate_en(relocate_en),
        .problem_state(problem_state), .access(access), .ea(ea),
        .hit(hit), .fault(fault), .ra(ra)
    );

    // Vector: {relocate, problem, access[1:0], ea, exp_hit, exp_fault, exp_ra}
    localparam int NV = 13;
    localparam logic [69:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'd0, 32'h1234_5678, 1'b0, 1'b0, 32'h1234_5678}, // R2
        {1'b1, 1'b0, 2'd0, 32'h1000_4321, 1'b1, 1'b0, 32'h8000_4321}, // R3 R5
        {1'b1, 1'b1, 2'd0, 32'h1000_4321, 1'b1, 1'b0, 32'h9000_4321}, // R3
        {1'b1, 1'b0, 2'd0, 32'h1002_0000, 1'b0, 1'b0, 32'h0000_0000}, // R4 R9
        {1'b1, 1'b0, 2'd0, 32'h201F_FFFC, 1'b1, 1'b0, 32'h401F_FFFC}, // R4 R5
        {1'b1, 1'b0, 2'd0, 32'h2020_0000, 1'b0, 1'b0, 32'h0000_0000}, // R4 R9
        {1'b1, 1'b0, 2'd1, 32'h2000_0010, 1'b1, 1'b1, 32'hFFFF_FFFF}, // R7 R8
        {1'b1, 1'b0, 2'd2, 32'h2000_0010, 1'b1, 1'b0, 32'h4000_0010}, // R7
        {1'b1, 1'b1, 2'd1, 32'h3ABC_DEF0, 1'b1, 1'b0, 32'h5ABC_DEF0}, // R4 R5
        {1'b1, 1'b1, 2'd1, 32'h1000_0008, 1'b1, 1'b0, 32'h9000_0008}, // R7
        {1'b0, 1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'hFFFF_FFFF}, // R2
        {1'b1, 1'b0, 2'd3, 32'h2000_0004, 1'b1, 1'b0, 32'h4000_0004}, // R7
        {1'b1, 1'b0, 2'd1, 32'h3000_0000, 1'b1, 1'b0, 32'h5000_0000}  // R5
    };

    task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got hit=%0b fault=%0b ra=%h expected hit=%0b fault=%0b ra=%h",
                     req, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic low, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_lower = low; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic rel, input logic prb, input logic [1:0] acc,
                        input logic [31:0] a, input string req, input logic [33:0] exp);
        @(negedge clk);
        relocate_en = rel; problem_state = prb; access = acc; ea = a;
        #2;
        check(req, {hit, fault, ra}, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_lower = 1'b0; wr_data = '0;
        relocate_en = 1'b0; problem_state = 1'b0; access = 2'd0; ea = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: cleared pairs give misses in both states
        look(1'b1, 1'b0, 2'd0, 32'h0000_0000, "R1 reset sup", {2'b00, 32'h0});
        look(1'b1, 1'b1, 2'd2, 32'h1000_0000, "R1 reset prob", {2'b00, 32'h0});

        // R10 programming: four windows
        wr(2'd0, 1'b0, 32'h1000_0002); wr(2'd0, 1'b1, 32'h8000_0002);
        wr(2'd1, 1'b0, 32'h2000_003F); wr(2'd1, 1'b1, 32'h4000_0001);
        wr(2'd2, 1'b0, 32'h1000_0001); wr(2'd2, 1'b1, 32'h9000_0002);
        wr(2'd3, 1'b0, 32'h3000_1FFF); wr(2'd3, 1'b1, 32'h5000_0002);

        for (int i = 0; i < NV; i++) begin
            look(VEC[i][69], VEC[i][68], VEC[i][67:66], VEC[i][65:34],
                 $sformatf("R2-R9 vector %0d", i), VEC[i][33:0]);
        end

        // R6 and R10: pair 3 moved over pair 1, only its upper register rewritten
        wr(2'd3, 1'b0, 32'h2000_1FFF);
        look(1'b1, 1'b0, 2'd0, 32'h2000_1234, "R6 lowest index", {2'b10, 32'h4000_1234});
        look(1'b1, 1'b0, 2'd1, 32'h2080_0000, "R6 R10 wider pair, lower kept", {2'b10, 32'h5080_0000});
        look(1'b1, 1'b0, 2'd0, 32'h3000_0000, "R10 old window gone", {2'b00, 32'h0});

        // R7 and R8: code 00 blocks fetch and load
        wr(2'd3, 1'b1, 32'h5000_0000);
        look(1'b1, 1'b0, 2'd2, 32'h2080_0000, "R7 no-access fetch", {2'b11, 32'hFFFF_FFFF});
        look(1'b1, 1'b1, 2'd0, 32'h2080_0000, "R8 no-access load", {2'b11, 32'hFFFF_FFFF});
        look(1'b0, 1'b1, 2'd0, 32'h2080_0000, "R2 no fault when off", {2'b00, 32'h2080_0000});

        // R1: a reset in mid-run clears the programmed windows
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        look(1'b1, 1'b0, 2'd0, 32'h1000_4321, "R1 mid-run reset", {2'b00, 32'h0});

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule